// File: doc/BRIEF.md
# Lockable Cache Replacement Way Selector

This block picks the victim way for refills of a 4-way set-associative cache, and it holds the control register that governs way locking. A pairwise-age record is kept for every set. It is refreshed whenever a hit is reported and whenever a refill way is granted. In the normal case the victim is the way that was used least recently in the addressed set.

When lock mode is active and a prefetch misses, the block can steer the refill into way 3 or way 2 instead, provided that way's load and lock bits are both set. Lock mode is active in two cases: the lock-enable bit is set, or the external DSP mode flag is high.

A small state machine runs the miss path. It has two states:
- `ST_IDLE`: no grant is pending.
- `ST_GRANT`: `victim_vld` is high for one cycle, and `victim_way` shows the way that was chosen.

It has three transitions:
- `T_MISS`: `ST_IDLE` to `ST_GRANT` when `miss_req` is high.
- `T_CHAIN`: `ST_GRANT` to `ST_GRANT` when another `miss_req` arrives.
- `T_DONE`: `ST_GRANT` to `ST_IDLE` when `miss_req` is low.

While in `ST_IDLE` with no request, the machine stays where it is.

Top module: `lockable_victim_sel`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and `victim_vld` is low.
- R2: Register bits 31..17, 15..10 and 7..2 always read as 0, whatever is written to them.
- R3: A write stores bit 16 (lock enable), bit 9 (way-3 load), bit 8 (way-3 lock), bit 1 (way-2 load) and bit 0 (way-2 lock). The stored values are readable on `cfg_rdata` from the cycle after the write. A miss in the same cycle as a write uses the old value.
- R4: Lock mode is active when bit 16 is 1, or when `dsp_mode` is 1. If neither holds, prefetch misses use the LRU choice even when a lock pair is complete.
- R5: A prefetch miss in lock mode with bits 9 and 8 both 1 yields way 3.
- R6: A prefetch miss in lock mode with bits 1 and 0 both 1, and the way-3 pair not complete, yields way 2.
- R7: If both lock pairs are complete, way 3 wins over way 2.
- R8: Every other miss yields the least-recently-used way of the set. This includes non-prefetch misses, misses outside lock mode, and misses with an incomplete pair.
- R9: Each hit (`hit_set`, `hit_way`) and each granted refill makes that way the most recent in its set. The victim is the way that is older than the other three.
- R10: Reset clears every set's age state, so the first victim in any set is way 0, and the order that follows is 1, 2, 3.
- R11: `victim_vld` is high in exactly the cycle after each cycle with `miss_req` high, and low otherwise. `victim_way` holds its value while no miss is taken.
- R12: If a hit and a miss name the same set in one cycle, the hit is dropped, and only the refill way becomes most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| dsp_mode | input | 1 | External mode flag that enables lock mode |
| miss_req | input | 1 | Refill request strobe |
| miss_prefetch | input | 1 | The missing access is a prefetch |
| miss_set | input | SET_W | Set index of the refill |
| hit_vld | input | 1 | Hit notification strobe |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | 2 | Way that hit |
| victim_vld | output | 1 | Victim grant valid |
| victim_way | output | 2 | Chosen victim way |

## Verification
A miss is sampled at a rising edge, and its grant appears on `victim_vld` and `victim_way` right after that edge. Register writes show up on `cfg_rdata` after the same edge, while age updates only affect misses taken at later edges. The bench's reference model advances on the rising edge with exactly these latencies. All outputs are compared against it on the falling edge that follows. Directed misses check the expected way on the falling edge one cycle after the request.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int AGE_W  = WAYS * (WAYS - 1) / 2;
    localparam int CFG_W  = 32;

    localparam int LE_BIT   = 16;
    localparam int W3LD_BIT = 9;
    localparam int W3LK_BIT = 8;
    localparam int W2LD_BIT = 1;
    localparam int W2LK_BIT = 0;

    localparam logic [CFG_W-1:0] CFG_MASK =
        (CFG_W'(1) << LE_BIT) | (CFG_W'(1) << W3LD_BIT) | (CFG_W'(1) << W3LK_BIT) |
        (CFG_W'(1) << W2LD_BIT) | (CFG_W'(1) << W2LK_BIT);

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [AGE_W-1:0] age_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } vs_state_e;

    // Pair bit k covers ways (i,j), i<j; a 1 means way i was used after way j.
    function automatic age_t age_touch(input age_t a, input way_t w);
        age_t r;
        int   k;
        r = a;
        k = 0;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (i == int'(w))      r[k] = 1'b1;
                else if (j == int'(w)) r[k] = 1'b0;
                k++;
            end
        end
        return r;
    endfunction

    // One bit per way, set when that way is older than all others.
    function automatic logic [WAYS-1:0] age_oldest(input age_t a);
        logic [WAYS-1:0] o;
        int k;
        o = '1;
        k = 0;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (a[k])  o[i] = 1'b0;
                else       o[j] = 1'b0;
                k++;
            end
        end
        return o;
    endfunction
endpackage

// File: rtl/lvs_cfg_reg.sv
module lvs_cfg_reg
    import lvs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg
);
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wr_data & CFG_MASK;
    end

    assign cfg = cfg_q;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg & ~CFG_MASK) == '0);

    p_wr_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg == ($past(wr_data) & CFG_MASK));
endmodule

// File: rtl/lvs_lru_bank.sv
module lvs_lru_bank
    import lvs_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int SET_W = $clog2(SETS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output way_t             rd_victim,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  way_t             fill_way,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  way_t             hit_way
);
    age_t            age_q [SETS];
    logic [WAYS-1:0] oldest;

    for (genvar g = 0; g < SETS; g++) begin : g_set
        logic fill_here;
        logic hit_here;
        assign fill_here = fill_en && (fill_set == SET_W'(g));
        assign hit_here  = hit_en  && (hit_set  == SET_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         age_q[g] <= '0;
            else if (fill_here) age_q[g] <= age_touch(age_q[g], fill_way);
            else if (hit_here)  age_q[g] <= age_touch(age_q[g], hit_way);
        end
    end

    always_comb begin
        oldest    = age_oldest(age_q[rd_set]);
        rd_victim = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (oldest[w]) rd_victim = way_t'(w);
        end
    end

    p_oldest_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest));

    p_fill_mru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_set == rd_set) |=> !(rd_set == $past(fill_set) &&
                                              rd_victim == $past(fill_way)));
endmodule

// File: rtl/lvs_way_pick.sv
module lvs_way_pick
    import lvs_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             dsp_mode,
    input  logic             prefetch,
    input  way_t             lru_way,
    output way_t             victim
);
    logic lock_on;
    logic pair3;
    logic pair2;

    always_comb begin
        lock_on = cfg[LE_BIT] | dsp_mode;
        pair3   = cfg[W3LD_BIT] & cfg[W3LK_BIT];
        pair2   = cfg[W2LD_BIT] & cfg[W2LK_BIT];
        victim  = lru_way;
        if (prefetch && lock_on) begin
            if (pair3)      victim = way_t'(3);
            else if (pair2) victim = way_t'(2);
        end
    end
endmodule

// File: rtl/lockable_victim_sel.sv
module lockable_victim_sel
    import lvs_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int SET_W = $clog2(SETS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             dsp_mode,
    input  logic             miss_req,
    input  logic             miss_prefetch,
    input  logic [SET_W-1:0] miss_set,
    input  logic             hit_vld,
    input  logic [SET_W-1:0] hit_set,
    input  logic [1:0]       hit_way,
    output logic             victim_vld,
    output logic [1:0]       victim_way
);
    vs_state_e        state_q, state_d;
    logic [CFG_W-1:0] cfg;
    way_t             lru_way;
    way_t             pick;
    way_t             way_q;
    logic             hit_keep;

    lvs_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    // A hit aimed at the set being refilled this cycle is dropped.
    assign hit_keep = hit_vld && !(miss_req && (hit_set == miss_set));

    lvs_lru_bank #(.SETS(SETS), .SET_W(SET_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (miss_set),
        .rd_victim (lru_way),
        .fill_en   (miss_req),
        .fill_set  (miss_set),
        .fill_way  (pick),
        .hit_en    (hit_keep),
        .hit_set   (hit_set),
        .hit_way   (hit_way)
    );

    lvs_way_pick u_pick (
        .cfg      (cfg),
        .dsp_mode (dsp_mode),
        .prefetch (miss_prefetch),
        .lru_way  (lru_way),
        .victim   (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            if (miss_req) way_q <= pick;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_req) state_d = ST_GRANT;          // T_MISS
            ST_GRANT: state_d = miss_req ? ST_GRANT : ST_IDLE;   // T_CHAIN / T_DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        victim_vld = (state_q == ST_GRANT);
        victim_way = way_q;
        cfg_rdata  = cfg;
    end

    p_grant_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |=> victim_vld);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_req |=> (!victim_vld && $stable(victim_way)));

    p_force3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && miss_prefetch && (cfg_rdata[LE_BIT] || dsp_mode) &&
         cfg_rdata[W3LD_BIT] && cfg_rdata[W3LK_BIT]) |=> victim_way == 2'd3);

    p_force2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && miss_prefetch && (cfg_rdata[LE_BIT] || dsp_mode) &&
         !(cfg_rdata[W3LD_BIT] && cfg_rdata[W3LK_BIT]) &&
         cfg_rdata[W2LD_BIT] && cfg_rdata[W2LK_BIT]) |=> victim_way == 2'd2);
endmodule

// File: tb/sim_lockable_victim_sel.sv
`timescale 1ns/1ps
module sim_lockable_victim_sel;
    localparam int SETS  = 16;
    localparam int SET_W = $clog2(SETS);
    localparam logic [31:0] MASK = 32'h0001_0303;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             dsp_mode = 1'b0;
    logic             miss_req = 1'b0;
    logic             miss_prefetch = 1'b0;
    logic [SET_W-1:0] miss_set = '0;
    logic             hit_vld = 1'b0;
    logic [SET_W-1:0] hit_set = '0;
    logic [1:0]       hit_way = '0;
    logic             victim_vld;
    logic [1:0]       victim_way;

    always #2 clk = ~clk;

    lockable_victim_sel #(.SETS(SETS)) u0 (.*);

    int    checks = 0;
    int    errs = 0;
    int    ord [SETS][4];
    logic [31:0] exp_reg = '0;
    logic  exp_vld = 1'b0;
    int    exp_way = 0;
    string exp_tag = "R10";
    bit    lock_m;
    int    v;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic touch(input int s, input int w);
        int p;
        p = 0;
        for (int i = 0; i < 4; i++) if (ord[s][i] == w) p = i;
        for (int i = p; i < 3; i++) ord[s][i] = ord[s][i+1];
        ord[s][3] = w;
    endtask

    // Reference model: advances on the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_reg = '0;
            exp_vld = 1'b0;
            exp_way = 0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < 4; w++) ord[s][w] = w;
        end else begin
            exp_vld = miss_req;
            if (miss_req) begin
                lock_m = exp_reg[16] | dsp_mode;
                if (miss_prefetch && lock_m && exp_reg[9] && exp_reg[8]) begin
                    v = 3; exp_tag = (exp_reg[1] && exp_reg[0]) ? "R7" : "R5";
                end else if (miss_prefetch && lock_m && exp_reg[1] && exp_reg[0]) begin
                    v = 2; exp_tag = "R6";
                end else begin
                    v = ord[miss_set][0];
                    exp_tag = (miss_prefetch && !lock_m &&
                               ((exp_reg[9] && exp_reg[8]) || (exp_reg[1] && exp_reg[0]))) ? "R4" : "R8";
                end
                exp_way = v;
                touch(int'(miss_set), v);
            end
            if (hit_vld && !(miss_req && hit_set == miss_set)) touch(int'(hit_set), int'(hit_way));
            if (cfg_we) exp_reg = cfg_wdata & MASK;
        end
    end

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            check(cfg_rdata == exp_reg, "R2", cfg_rdata, exp_reg);
            check(victim_vld == exp_vld, "R11", victim_vld, exp_vld);
            if (exp_vld) check(victim_way == 2'(exp_way), exp_tag, victim_way, exp_way);
        end
    end

    task automatic wr_cfg(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic miss_exp(input int s, input bit pf, input int expw, input string tag);
        @(negedge clk); miss_req = 1'b1; miss_prefetch = pf; miss_set = SET_W'(s);
        @(negedge clk); miss_req = 1'b0; miss_prefetch = 1'b0;
        check(victim_vld && victim_way == 2'(expw), tag, victim_way, expw);
    endtask

    task automatic hit(input int s, input int w);
        @(negedge clk); hit_vld = 1'b1; hit_set = SET_W'(s); hit_way = 2'(w);
        @(negedge clk); hit_vld = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cfg_rdata == 32'h0 && !victim_vld, "R1", cfg_rdata, 0);
        rst_n = 1'b1;
        // R2 R3: writable and reserved bits
        wr_cfg(32'hFFFF_FFFF);
        check(cfg_rdata == MASK, "R3", cfg_rdata, MASK);
        wr_cfg(32'hFFFE_FCFC);
        check(cfg_rdata == 32'h0, "R2", cfg_rdata, 0);
        // R10: fresh sets start at way 0, then 1, 2, 3
        miss_exp(0, 0, 0, "R10");
        miss_exp(0, 0, 1, "R10");
        miss_exp(0, 0, 2, "R10");
        miss_exp(0, 0, 3, "R10");
        miss_exp(0, 0, 0, "R8");
        miss_exp(1, 1, 0, "R10");
        // R9: hits reorder the set
        hit(2, 0); hit(2, 2); hit(2, 1);
        miss_exp(2, 0, 3, "R9");
        miss_exp(2, 0, 0, "R9");
        // R12: hit to the refilled set in the same cycle is dropped
        @(negedge clk); miss_req = 1'b1; miss_set = 5; hit_vld = 1'b1; hit_set = 5; hit_way = 1;
        @(negedge clk); miss_req = 1'b0; hit_vld = 1'b0;
        check(victim_way == 2'd0, "R12", victim_way, 0);
        miss_exp(5, 0, 1, "R12");
        // Lock behaviour on set 7
        wr_cfg(32'h0000_0300);
        miss_exp(7, 1, 0, "R4");
        dsp_mode = 1'b1;
        miss_exp(7, 1, 3, "R5");
        miss_exp(7, 0, 1, "R8");
        dsp_mode = 1'b0;
        wr_cfg(32'h0001_0300);
        miss_exp(7, 1, 3, "R4");
        wr_cfg(32'h0001_0003);
        miss_exp(7, 1, 2, "R6");
        wr_cfg(32'h0001_0002);
        miss_exp(7, 1, 0, "R8");
        wr_cfg(32'h0001_0303);
        miss_exp(7, 1, 3, "R7");
        // R3: write and miss in one cycle use the old value
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0; miss_req = 1'b1; miss_prefetch = 1'b1; miss_set = 9;
        @(negedge clk); cfg_we = 1'b0; miss_req = 1'b0; miss_prefetch = 1'b0;
        check(victim_way == 2'd3, "R3", victim_way, 3);
        // Random mix, compared against the model on every cycle
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            cfg_we        = ($urandom_range(0, 15) == 0);
            cfg_wdata     = $urandom();
            dsp_mode      = $urandom_range(0, 1);
            miss_req      = $urandom_range(0, 1);
            miss_prefetch = $urandom_range(0, 1);
            miss_set      = SET_W'($urandom_range(0, 3));
            hit_vld       = $urandom_range(0, 1);
            hit_set       = SET_W'($urandom_range(0, 3));
            hit_way       = 2'($urandom_range(0, 3));
        end
        @(negedge clk);
        cfg_we = 1'b0; miss_req = 1'b0; hit_vld = 1'b0;
        repeat (3) @(negedge clk);
        report();
    end
endmodule